// File: doc/BRIEF.md
# Serial Configuration Bitstream Reader

This block is a read-only, one-bit-wide memory that streams a stored configuration image to a programmable logic device acting as the clock master. The device supplies the configuration clock. It also drives an active-low chip enable and a combined reset/output-enable pin, whose reset polarity is chosen by a select input. On every clock edge where reading is allowed, the block presents the bit at its internal bit counter and then advances the counter by one.

A reset level on the reset/output-enable pin clears the counter and turns the output off, whatever chip enable is doing. A high chip enable freezes the counter, turns the output off and raises a standby flag. A low level on the serial-enable input selects programming mode. In that mode the read path is dead and chip enable has no effect. The tri-state data pin is modelled as a data bit and a separate enable. The data bit reads 0 whenever the enable is off. A parallel write port fills the bit array. The array depth is a parameter. Production sizes run from 256 Kbit to 4 Mbit, and smaller depths serve simulation.

Top module: `cfgrom_reader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter is cleared and `dout_en`, `dout` and `standby` are 0. The first read after reset therefore returns the bit at address 0.
- R2: In read mode, each edge sets `dout_en` to 1 and `dout` to the bit at the counter, then advances the counter by one. Read mode means `ser_en`=1, `ce_n`=0 and `rst_oe` not at its reset level.
- R3: With `ser_en`=1 and `rst_oe` at its reset level, an edge clears the counter and sets `dout_en` to 0, for either value of `ce_n`.
- R4: The reset level of `rst_oe` equals `rst_pol`. With `rst_pol`=0, low resets and high enables. With `rst_pol`=1, high resets and low enables.
- R5: With `ser_en`=1, `ce_n`=1 and `rst_oe` at its enable level, an edge holds the counter and sets `dout_en` to 0. When `ce_n` returns low, reading resumes at the held address. After a reset pulse, the counter stays disabled while `ce_n` remains high.
- R6: After each edge, `standby` equals `ser_en` AND `ce_n` as sampled on that edge. This includes edges where `rst_oe` is at its reset level.
- R7: With `ser_en`=0, an edge sets `dout_en` and `standby` to 0 and holds the counter, for any `ce_n` and `rst_oe`.
- R8: A read at address DEPTH-1 is followed by a read at address 0.
- R9: An edge with `pl_we`=1 stores `pl_data` at `pl_addr`, and later reads of that address return it.
- R10: `dout` is 0 whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock from the master device |
| rst_n | input | 1 | Power-on reset, active low, sampled on `clk` |
| ser_en | input | 1 | 1 = readout mode, 0 = programming mode (read path off) |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined counter reset / output enable |
| rst_pol | input | 1 | Level of `rst_oe` that means reset |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | $clog2(DEPTH) | Preload bit address |
| pl_data | input | 1 | Preload bit value |
| dout | output | 1 | Serial data bit, 0 when not driven |
| dout_en | output | 1 | Output driver enable (models the tri-state buffer) |
| standby | output | 1 | Low-power standby indication |

## Verification
The hardest situation to reach is the interplay of a reset pulse with a chip enable that stays high. The counter must be cleared and then stay frozen until chip enable falls. The bench reads part of the image, raises chip enable together with the reset level, and drops the reset level while chip enable is still high. It then checks that the first bit after chip enable falls comes from address 0. Counter wrap is reached with a 32-bit array read for more than one full pass. Programming mode is entered in the middle of a run to show that the address is held.

// File: rtl/cfgrom_pkg.sv
// Shared types for the serial configuration bitstream reader.
// Assumes: nothing beyond IEEE 1800-2017.
package cfgrom_pkg;

    // Operating mode decoded from the control pins on each clock edge.
    typedef enum logic [1:0] {
        MODE_PROG  = 2'd0,   // programming mode, read path inactive
        MODE_CLEAR = 2'd1,   // reset level on reset/OE pin
        MODE_HOLD  = 2'd2,   // chip enable high, standby
        MODE_READ  = 2'd3    // stream one bit per edge
    } rd_mode_e;

endpackage

// File: rtl/cfgrom_mode_dec.sv
// Decodes the control pins into one operating mode plus the next standby value.
// Priority: programming mode, then reset level, then chip enable.
// Assumes: pins are already synchronous to clk.
module cfgrom_mode_dec
    import cfgrom_pkg::*;
(
    input  logic     ser_en,
    input  logic     ce_n,
    input  logic     rst_oe,
    input  logic     rst_pol,
    output rd_mode_e mode,
    output logic     standby_nxt
);

    logic reset_lvl;

    // Reset level is the pin value matching the programmed polarity.
    always_comb begin
        reset_lvl = (rst_oe == rst_pol);
    end

    // Mode priority decode.
    always_comb begin
        if (!ser_en) begin
            mode = MODE_PROG;
        end else if (reset_lvl) begin
            mode = MODE_CLEAR;
        end else if (ce_n) begin
            mode = MODE_HOLD;
        end else begin
            mode = MODE_READ;
        end
    end

    // Standby follows chip enable only while in readout mode.
    always_comb begin
        standby_nxt = ser_en & ce_n;
    end

endmodule

// File: rtl/cfgrom_bit_ctr.sv
// Bit address counter: clears, holds or advances with wrap at DEPTH-1.
// Assumes: synchronous active-low reset; DEPTH >= 2.
module cfgrom_bit_ctr #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Counter update: reset/clear to 0, advance with wrap, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr <= '0;
        end else if (adv) begin
            addr <= (addr == LAST) ? '0 : addr + AW'(1);
        end
    end

endmodule

// File: rtl/cfgrom_bit_store.sv
// DEPTH x 1 bit array with a synchronous preload write port and an
// asynchronous read port addressed by the bit counter.
// Assumes: contents are not reset; preload happens before readout.
module cfgrom_bit_store #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr,
    output logic          rbit
);

    logic bits_q [DEPTH];

    // Preload write.
    always_ff @(posedge clk) begin
        if (we) begin
            bits_q[waddr] <= wdata;
        end
    end

    // Read of the addressed bit.
    always_comb begin
        rbit = bits_q[raddr];
    end

endmodule

// File: rtl/cfgrom_out_stage.sv
// Registered output driver: data bit, driver enable and standby flag.
// Data is forced to 0 whenever the driver is off.
// Assumes: synchronous active-low reset.
module cfgrom_out_stage
    import cfgrom_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rd_mode_e mode,
    input  logic     standby_nxt,
    input  logic     rbit,
    output logic     dout,
    output logic     dout_en,
    output logic     standby
);

    // Output register update per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= 1'b0;
            dout_en <= 1'b0;
            standby <= 1'b0;
        end else begin
            standby <= standby_nxt;
            if (mode == MODE_READ) begin
                dout    <= rbit;
                dout_en <= 1'b1;
            end else begin
                dout    <= 1'b0;
                dout_en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cfgrom_reader.sv
// Top level of the serial configuration bitstream reader.
// Streams one stored bit per clock while enabled; see doc/BRIEF.md.
// Assumes: all inputs synchronous to clk; DEPTH >= 2.
module cfgrom_reader
    import cfgrom_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_en,
    input  logic          ce_n,
    input  logic          rst_oe,
    input  logic          rst_pol,
    input  logic          pl_we,
    input  logic [AW-1:0] pl_addr,
    input  logic          pl_data,
    output logic          dout,
    output logic          dout_en,
    output logic          standby
);

    rd_mode_e      mode;
    logic          standby_nxt;
    logic [AW-1:0] bit_addr;
    logic          rbit;
    logic          ctr_clr;
    logic          ctr_adv;

    cfgrom_mode_dec u_dec (
        .ser_en      (ser_en),
        .ce_n        (ce_n),
        .rst_oe      (rst_oe),
        .rst_pol     (rst_pol),
        .mode        (mode),
        .standby_nxt (standby_nxt)
    );

    // Counter controls from the decoded mode.
    always_comb begin
        ctr_clr = (mode == MODE_CLEAR);
        ctr_adv = (mode == MODE_READ);
    end

    cfgrom_bit_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .adv   (ctr_adv),
        .addr  (bit_addr)
    );

    cfgrom_bit_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (pl_we),
        .waddr (pl_addr),
        .wdata (pl_data),
        .raddr (bit_addr),
        .rbit  (rbit)
    );

    cfgrom_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .standby_nxt (standby_nxt),
        .rbit        (rbit),
        .dout        (dout),
        .dout_en     (dout_en),
        .standby     (standby)
    );

endmodule

// File: rtl/cfgrom_reader_chk.sv
// Checker for cfgrom_reader, attached by bind. Observes ports and the
// bit counter address.
module cfgrom_reader_chk #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ser_en,
    input logic          ce_n,
    input logic          rst_oe,
    input logic          rst_pol,
    input logic          dout,
    input logic          dout_en,
    input logic          standby,
    input logic [AW-1:0] bit_addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    AST_OFF_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> !dout); // R10

    AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && !ce_n && (rst_oe != rst_pol)) |=>
        (dout_en && !standby && bit_addr == (($past(bit_addr) == LAST) ? '0 : $past(bit_addr) + AW'(1)))); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && (rst_oe == rst_pol)) |=> (bit_addr == '0 && !dout_en)); // R3

    AST_CE_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && ce_n && (rst_oe != rst_pol)) |=> ($stable(bit_addr) && !dout_en && standby)); // R5

    AST_STANDBY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && ce_n) |=> standby); // R6

    AST_PROG_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> ($stable(bit_addr) && !dout_en && !standby)); // R7

endmodule

bind cfgrom_reader cfgrom_reader_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_en   (ser_en),
    .ce_n     (ce_n),
    .rst_oe   (rst_oe),
    .rst_pol  (rst_pol),
    .dout     (dout),
    .dout_en  (dout_en),
    .standby  (standby),
    .bit_addr (bit_addr)
);

// File: tb/tb_cfgrom_reader.sv
module tb_cfgrom_reader;

    localparam int DEPTH = 32;
    localparam int AW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n, ser_en, ce_n, rst_oe, rst_pol;
    logic          pl_we, pl_data;
    logic [AW-1:0] pl_addr;
    logic          dout, dout_en, standby;

    logic model [DEPTH];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cfgrom_reader #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ce_n(ce_n),
        .rst_oe(rst_oe), .rst_pol(rst_pol), .pl_we(pl_we),
        .pl_addr(pl_addr), .pl_data(pl_data), .dout(dout),
        .dout_en(dout_en), .standby(standby)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic e_en, logic e_d, logic e_sb);
        n_cmp++;
        if (dout_en !== e_en || dout !== e_d || standby !== e_sb) begin
            n_bad++;
            $display("FAIL %s: got en=%b d=%b sb=%b expected en=%b d=%b sb=%b",
                     req, dout_en, dout, standby, e_en, e_d, e_sb);
        end
    endtask

    // Stream count bits starting at address start, checking each one.
    task automatic read_run(string req, int start, int count);
        for (int k = 0; k < count; k++) begin
            tick();
            check(req, 1'b1, model[(start + k) % DEPTH], 1'b0);
        end
    endtask

    // R1: power-on reset state and first read from address 0.
    task automatic t_power_on();
        rst_n = 1'b0; ser_en = 1'b1; ce_n = 1'b1; rst_oe = 1'b1; rst_pol = 1'b0;
        pl_we = 1'b0; pl_addr = '0; pl_data = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = 1'(((i * 13 + 5) >> 2) ^ (i & 1));
            pl_we = 1'b1; pl_addr = AW'(i); pl_data = model[i];
            tick();
        end
        pl_we = 1'b0;
        tick();
        check("R1 reset state", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1; ce_n = 1'b0;
        read_run("R1 first bit after power-on", 0, 1);
    endtask

    // R2: streaming of consecutive bits.
    task automatic t_stream();
        read_run("R2 stream", 1, 10);
    endtask

    // R5/R6: chip enable high holds the counter and raises standby.
    task automatic t_ce_hold();
        ce_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R5 ce_n high output off", 1'b0, 1'b0, 1'b1);
        end
        ce_n = 1'b0;
        read_run("R5 resume at held address", 11, 3);
    endtask

    // R3/R6/R5: reset overrides chip enable; counter stays disabled until ce_n falls.
    task automatic t_reset_override();
        ce_n = 1'b1; rst_oe = 1'b0;
        tick();
        check("R6 standby during reset level", 1'b0, 1'b0, 1'b1);
        rst_oe = 1'b1;
        tick();
        check("R5 still disabled after reset pulse", 1'b0, 1'b0, 1'b1);
        tick();
        check("R5 still disabled after reset pulse", 1'b0, 1'b0, 1'b1);
        ce_n = 1'b0;
        read_run("R3 restart from 0 after reset with ce_n high", 0, 4);
        rst_oe = 1'b0;
        tick();
        check("R3 reset with ce_n low", 1'b0, 1'b0, 1'b0);
        rst_oe = 1'b1;
        read_run("R3 restart from 0 after reset with ce_n low", 0, 2);
    endtask

    // R4: inverted polarity.
    task automatic t_polarity();
        rst_pol = 1'b1; rst_oe = 1'b1;
        tick();
        check("R4 high resets when inverted", 1'b0, 1'b0, 1'b0);
        rst_oe = 1'b0;
        read_run("R4 low enables when inverted", 0, 5);
        rst_oe = 1'b1;
        tick();
        check("R4 high resets when inverted", 1'b0, 1'b0, 1'b0);
        rst_pol = 1'b0;
        read_run("R4 default polarity high enables", 0, 3);
    endtask

    // R7: programming mode silences the read path and holds the address.
    task automatic t_prog();
        ser_en = 1'b0;
        tick();
        check("R7 prog mode ce_n low", 1'b0, 1'b0, 1'b0);
        ce_n = 1'b1;
        tick();
        check("R7 prog mode ce_n high no standby", 1'b0, 1'b0, 1'b0);
        rst_oe = 1'b0;
        tick();
        check("R7 prog mode ignores reset level", 1'b0, 1'b0, 1'b0);
        rst_oe = 1'b1; ce_n = 1'b0; ser_en = 1'b1;
        read_run("R7 address held through prog mode", 3, 2);
    endtask

    // R8: counter wrap.
    task automatic t_wrap();
        rst_oe = 1'b0;
        tick();
        rst_oe = 1'b1;
        read_run("R8 wrap", 0, DEPTH + 4);
    endtask

    // R9: preload rewrites a bit seen on a later pass.
    task automatic t_preload();
        ce_n = 1'b1;
        pl_we = 1'b1; pl_addr = AW'(2); pl_data = ~model[2];
        tick();
        check("R9 preload in standby", 1'b0, 1'b0, 1'b1);
        model[2] = ~model[2];
        pl_we = 1'b0; rst_oe = 1'b0;
        tick();
        rst_oe = 1'b1; ce_n = 1'b0;
        read_run("R9 preloaded bit read back", 0, 4);
    endtask

    initial begin
        t_power_on();
        t_stream();
        t_ce_hold();
        t_reset_override();
        t_polarity();
        t_prog();
        t_wrap();
        t_preload();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule